// File: doc/BRIEF.md
# Gate-Scan Clock Output Controller

This block is the digital control core of a two-channel gate-scan driver for a thin-film display panel. It receives a frame-start level and one line-clock input per channel, all asynchronous to the system clock. For every channel it produces a level code for a true scan clock and for its complementary scan clock, plus a charge-share enable. It also produces a level code for a start-pulse output. An analog stage outside this block turns each code into a high-rail drive, a low-rail drive or a released, high-impedance pin.

While frame-start is high, each channel's scan clock follows its line clock directly. While frame-start is low, each line-clock rising edge flips that channel's driven pair. A low line clock releases both pins of the channel and turns charge sharing on, so the panel load can balance between the two lines. An on-chip power sequencer has two controls. The first is a run input. When run is low, every output is forced to one level and the toggle state is cleared. The second input chooses whether that forced level is low-rail or high-impedance.

Top module: `gsc_scan_ctrl`

## Requirements
- R1: Every level code is 2'b00 for high-impedance, 2'b01 for low-rail or 2'b10 for high-rail. The code 2'b11 never appears. Channel i uses bits [2i+1:2i] of trueCode and compCode, and bit i of shareEn and lineClkIn.
- R2: With run high and frame-start high, a channel's true code is high-rail when its line clock is high and low-rail when it is low. The complementary code is the opposite rail and charge share is off. The channel's toggle state loads the level being driven.
- R3: With run high and frame-start low, each rising edge of a channel's line clock swaps the rails on its true and complementary codes.
- R4: With run high and frame-start low, a channel whose line clock stays high keeps the rails it last drove.
- R5: With run high and frame-start low, a channel whose line clock is low shows high-impedance on both codes and raises its charge-share enable. Its toggle state is kept.
- R6: With run high, the start code is low-rail when frame-start is low. When frame-start is high it is high-rail if line clock 0 is low and high-impedance if line clock 0 is high.
- R7: The channels are independent. An edge or level on one channel's line clock never changes another channel's codes or charge-share enable.
- R8: With run low, every code shows low-rail when seqHiZ is 0 and high-impedance when seqHiZ is 1. Every charge-share enable is 0, and line-clock edges have no effect.
- R9: While run is low every toggle state is cleared. The first driven level after run returns, with frame-start low and the line clock high, is low-rail on the true code and high-rail on the complementary code.
- R10: Frame-start and line-clock inputs pass a two-flop synchronizer, so a change reaches the codes after the second rising clock edge. During reset the synchronizers read every input as low.
- R11: When frame-start falls and a line clock rises in the same synchronized cycle, the edge counts as a toggle from the state loaded while frame-start was high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low asynchronous reset |
| frameStartIn | input | 1 | Asynchronous frame-start level |
| lineClkIn | input | NUM_CH | Asynchronous line clocks, bit i for channel i |
| seqRun | input | 1 | Sequencer run control; low forces all outputs |
| seqHiZ | input | 1 | Forced level while run is low: 1 high-impedance, 0 low-rail |
| trueCode | output | 2*NUM_CH | True scan-clock level codes |
| compCode | output | 2*NUM_CH | Complementary scan-clock level codes |
| shareEn | output | NUM_CH | Charge-share enables |
| startCode | output | 2 | Start-pulse level code |

## Verification
Two functions can act in the same cycle: the end of the forced-follow phase, when frame-start falls, and a toggle on a line-clock rising edge. The bench provokes this by changing frame-start and both line clocks on one clock edge, so the two arrive through the synchronizers together. The result is judged by the rails that follow, which must be the inverse of the levels loaded while frame-start was high. A second collision comes from a line clock that is already high when run returns. This must not count as an edge, and the outputs must come up in the cleared toggle state.

// File: rtl/gsc_pkg.sv
package gsc_pkg;

  typedef enum logic [1:0] {
    LVL_HIZ  = 2'b00,
    LVL_LOW  = 2'b01,
    LVL_HIGH = 2'b10
  } lvl_e;

  typedef struct packed {
    logic lvl;
    logic rise;
  } lineStrobe_t;

  typedef struct packed {
    logic frameLvl;
    logic runOn;
    logic forceHiZ;
  } ctrlStrobe_t;

endpackage

// File: rtl/gsc_sync.sv
module gsc_sync #(
  parameter int WIDTH = 1
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [WIDTH-1:0] asyncIn,
  output logic [WIDTH-1:0] syncOut
);

  logic [WIDTH-1:0] metaStage;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      metaStage <= '0;
      syncOut   <= '0;
    end else begin
      metaStage <= asyncIn;
      syncOut   <= metaStage;
    end
  end

endmodule

// File: rtl/gsc_ctrl.sv
module gsc_ctrl
  import gsc_pkg::*;
#(
  parameter int NUM_CH = 2
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  logic                     frameStartIn,
  input  logic [NUM_CH-1:0]        lineClkIn,
  input  logic                     seqRun,
  input  logic                     seqHiZ,
  output ctrlStrobe_t              ctl,
  output lineStrobe_t [NUM_CH-1:0] line
);

  localparam int SYNC_W = NUM_CH + 1;

  logic [SYNC_W-1:0] syncVec;
  logic [NUM_CH-1:0] prevLine;

  gsc_sync #(.WIDTH(SYNC_W)) inSync (
    .clk     (clk),
    .rstN    (rstN),
    .asyncIn ({frameStartIn, lineClkIn}),
    .syncOut (syncVec)
  );

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) prevLine <= '0;
    else       prevLine <= syncVec[NUM_CH-1:0];
  end

  assign ctl.frameLvl = syncVec[NUM_CH];
  assign ctl.runOn    = seqRun;
  assign ctl.forceHiZ = seqHiZ;

  for (genvar i = 0; i < NUM_CH; i++) begin : g_line
    assign line[i].lvl  = syncVec[i];
    assign line[i].rise = syncVec[i] & ~prevLine[i];
  end

endmodule

// File: rtl/gsc_datapath.sv
module gsc_datapath
  import gsc_pkg::*;
#(
  parameter int NUM_CH   = 2,
  parameter int START_CH = 0
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  ctrlStrobe_t              ctl,
  input  lineStrobe_t [NUM_CH-1:0] line,
  output logic [2*NUM_CH-1:0]      trueCode,
  output logic [2*NUM_CH-1:0]      compCode,
  output logic [NUM_CH-1:0]        shareEn,
  output logic [1:0]               startCode
);

  lvl_e forcedLvl;
  assign forcedLvl = ctl.forceHiZ ? LVL_HIZ : LVL_LOW;

  for (genvar i = 0; i < NUM_CH; i++) begin : g_ch
    logic togReg;
    logic togNow;
    lvl_e tLvl;
    lvl_e cLvl;
    logic shareOn;

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)                                togReg <= 1'b0;
      else if (!ctl.runOn)                      togReg <= 1'b0;
      else if (ctl.frameLvl)                    togReg <= line[i].lvl;
      else if (line[i].rise)                    togReg <= ~togReg;
    end

    // the edge cycle already shows the flipped level
    assign togNow = (!ctl.frameLvl && line[i].rise) ? ~togReg : togReg;

    always_comb begin
      tLvl    = LVL_HIZ;
      cLvl    = LVL_HIZ;
      shareOn = 1'b0;
      if (!ctl.runOn) begin
        tLvl = forcedLvl;
        cLvl = forcedLvl;
      end else if (ctl.frameLvl) begin
        tLvl = line[i].lvl ? LVL_HIGH : LVL_LOW;
        cLvl = line[i].lvl ? LVL_LOW  : LVL_HIGH;
      end else if (line[i].lvl) begin
        tLvl = togNow ? LVL_HIGH : LVL_LOW;
        cLvl = togNow ? LVL_LOW  : LVL_HIGH;
      end else begin
        shareOn = 1'b1;
      end
    end

    assign trueCode[2*i +: 2] = tLvl;
    assign compCode[2*i +: 2] = cLvl;
    assign shareEn[i]         = shareOn;
  end

  always_comb begin
    if (!ctl.runOn)                startCode = forcedLvl;
    else if (!ctl.frameLvl)        startCode = LVL_LOW;
    else if (line[START_CH].lvl)   startCode = LVL_HIZ;
    else                           startCode = LVL_HIGH;
  end

endmodule

// File: rtl/gsc_scan_ctrl.sv
module gsc_scan_ctrl
  import gsc_pkg::*;
#(
  parameter int NUM_CH   = 2,
  parameter int START_CH = 0
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                frameStartIn,
  input  logic [NUM_CH-1:0]   lineClkIn,
  input  logic                seqRun,
  input  logic                seqHiZ,
  output logic [2*NUM_CH-1:0] trueCode,
  output logic [2*NUM_CH-1:0] compCode,
  output logic [NUM_CH-1:0]   shareEn,
  output logic [1:0]          startCode
);

  ctrlStrobe_t              ctlStb;
  lineStrobe_t [NUM_CH-1:0] lineStb;

  gsc_ctrl #(.NUM_CH(NUM_CH)) ctrlCore (
    .clk          (clk),
    .rstN         (rstN),
    .frameStartIn (frameStartIn),
    .lineClkIn    (lineClkIn),
    .seqRun       (seqRun),
    .seqHiZ       (seqHiZ),
    .ctl          (ctlStb),
    .line         (lineStb)
  );

  gsc_datapath #(.NUM_CH(NUM_CH), .START_CH(START_CH)) dataCore (
    .clk       (clk),
    .rstN      (rstN),
    .ctl       (ctlStb),
    .line      (lineStb),
    .trueCode  (trueCode),
    .compCode  (compCode),
    .shareEn   (shareEn),
    .startCode (startCode)
  );

endmodule

// File: rtl/gsc_scan_ctrl_chk.sv
module gsc_scan_ctrl_chk #(
  parameter int NUM_CH   = 2,
  parameter int START_CH = 0
) (
  input logic                clk,
  input logic                rstN,
  input logic                seqRun,
  input logic                seqHiZ,
  input logic [2*NUM_CH-1:0] trueCode,
  input logic [2*NUM_CH-1:0] compCode,
  input logic [NUM_CH-1:0]   shareEn,
  input logic [1:0]          startCode
);

  p_start_legal_r1: assert property (@(posedge clk) disable iff (!rstN)
    startCode != 2'b11);

  p_start_hiz_r6: assert property (@(posedge clk) disable iff (!rstN)
    (seqRun && startCode == 2'b00) |-> trueCode[2*START_CH +: 2] == 2'b10);

  for (genvar i = 0; i < NUM_CH; i++) begin : g_chk
    p_code_legal_r1: assert property (@(posedge clk) disable iff (!rstN)
      trueCode[2*i +: 2] != 2'b11 && compCode[2*i +: 2] != 2'b11);

    p_share_release_r5: assert property (@(posedge clk) disable iff (!rstN)
      shareEn[i] |-> (trueCode[2*i +: 2] == 2'b00 && compCode[2*i +: 2] == 2'b00));

    p_pair_opposite_r2: assert property (@(posedge clk) disable iff (!rstN)
      (seqRun && trueCode[2*i +: 2] == 2'b10) |-> compCode[2*i +: 2] == 2'b01);

    p_pair_opposite_low_r3: assert property (@(posedge clk) disable iff (!rstN)
      (seqRun && trueCode[2*i +: 2] == 2'b01) |-> compCode[2*i +: 2] == 2'b10);

    p_forced_level_r8: assert property (@(posedge clk) disable iff (!rstN)
      !seqRun |-> (!shareEn[i] && trueCode[2*i +: 2] == (seqHiZ ? 2'b00 : 2'b01)
                   && compCode[2*i +: 2] == trueCode[2*i +: 2]));
  end

endmodule

bind gsc_scan_ctrl gsc_scan_ctrl_chk #(.NUM_CH(NUM_CH), .START_CH(START_CH)) chk (
  .clk       (clk),
  .rstN      (rstN),
  .seqRun    (seqRun),
  .seqHiZ    (seqHiZ),
  .trueCode  (trueCode),
  .compCode  (compCode),
  .shareEn   (shareEn),
  .startCode (startCode)
);

// File: tb/gsc_scan_ctrl_test.sv
module gsc_scan_ctrl_test;

  localparam int NCH = 2;
  localparam int NVEC = 15;

  // {frame, line[1:0], run, hiz, true[3:0], comp[3:0], share[1:0], start[1:0]}
  localparam logic [16:0] VEC [NVEC] = '{
    17'b0_00_0_0_0101_0101_00_01,
    17'b0_00_0_1_0000_0000_00_00,
    17'b1_00_1_0_0101_1010_00_10,
    17'b1_01_1_0_0110_1001_00_00,
    17'b0_01_1_0_0010_0001_10_01,
    17'b0_10_1_0_1000_0100_01_01,
    17'b0_11_1_0_1001_0110_00_01,
    17'b0_00_1_0_0000_0000_11_01,
    17'b0_11_1_0_0110_1001_00_01,
    17'b0_11_0_0_0101_0101_00_01,
    17'b0_11_1_0_0101_1010_00_01,
    17'b1_11_1_0_1010_0101_00_00,
    17'b1_11_0_1_0000_0000_00_00,
    17'b0_00_0_1_0000_0000_00_00,
    17'b0_00_1_0_0000_0000_11_01
  };

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic frameStartIn = 1'b0;
  logic [NCH-1:0] lineClkIn = '0;
  logic seqRun = 1'b0;
  logic seqHiZ = 1'b0;
  logic [2*NCH-1:0] trueCode;
  logic [2*NCH-1:0] compCode;
  logic [NCH-1:0] shareEn;
  logic [1:0] startCode;

  int nRun = 0;
  int nFail = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  gsc_scan_ctrl #(.NUM_CH(NCH), .START_CH(0)) uut (
    .clk(clk), .rstN(rstN), .frameStartIn(frameStartIn), .lineClkIn(lineClkIn),
    .seqRun(seqRun), .seqHiZ(seqHiZ), .trueCode(trueCode), .compCode(compCode),
    .shareEn(shareEn), .startCode(startCode)
  );

  function automatic string tagOf(int idx);
    case (idx)
      0, 1, 9, 12, 13: return "R8";
      2:               return "R2,R1";
      3:               return "R6,R2";
      4:               return "R4";
      5:               return "R7,R3";
      6, 8:            return "R3";
      7, 14:           return "R5";
      10:              return "R9";
      11:              return "R2,R6";
      default:         return "R1";
    endcase
  endfunction

  task automatic checkVal(string tag, string what, logic [3:0] act, logic [3:0] exp);
    nRun++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s %s actual=%b expected=%b", tag, what, act, exp);
    end
  endtask

  task automatic checkAll(string tag, logic [3:0] eT, logic [3:0] eC, logic [1:0] eS, logic [1:0] eP);
    checkVal(tag, "trueCode", trueCode, eT);
    checkVal(tag, "compCode", compCode, eC);
    checkVal(tag, "shareEn", {2'b00, shareEn}, {2'b00, eS});
    checkVal(tag, "startCode", {2'b00, startCode}, {2'b00, eP});
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      nFail++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("  [TB] %0d tests run, %0d failed", nRun, nFail);
      $finish;
    end
  end

  initial begin
    // R10: reset clears synchronizers, inputs read as low
    seqRun = 1'b1;
    frameStartIn = 1'b1;
    lineClkIn = 2'b11;
    repeat (3) @(posedge clk);
    @(negedge clk);
    checkAll("R10", 4'b0000, 4'b0000, 2'b11, 2'b01);
    rstN = 1'b1;

    for (int k = 0; k < NVEC; k++) begin
      @(negedge clk);
      frameStartIn = VEC[k][16];
      lineClkIn    = VEC[k][15:14];
      seqRun       = VEC[k][13];
      seqHiZ       = VEC[k][12];
      repeat (4) @(posedge clk);
      @(negedge clk);
      checkAll(tagOf(k), VEC[k][11:8], VEC[k][7:4], VEC[k][3:2], VEC[k][1:0]);
    end

    // R10: a line-clock rise shows after the second clock edge, not the first
    @(negedge clk);
    lineClkIn = 2'b01;
    @(posedge clk);
    @(negedge clk);
    checkVal("R10", "ch0 after one edge", {2'b00, trueCode[1:0]}, 4'b0000);
    @(posedge clk);
    @(negedge clk);
    checkVal("R10", "ch0 after two edges", {2'b00, trueCode[1:0]}, 4'b0010);

    // R11: frame-start falls and both line clocks rise together
    @(negedge clk);
    frameStartIn = 1'b1;
    lineClkIn = 2'b00;
    repeat (4) @(posedge clk);
    @(negedge clk);
    frameStartIn = 1'b0;
    lineClkIn = 2'b11;
    repeat (4) @(posedge clk);
    @(negedge clk);
    checkAll("R11", 4'b1010, 4'b0101, 2'b00, 2'b01);

    // R8: edges while run is low leave the cleared state (R9 on return)
    @(negedge clk);
    seqRun = 1'b0;
    lineClkIn = 2'b00;
    repeat (3) @(posedge clk);
    @(negedge clk);
    lineClkIn = 2'b11;
    repeat (4) @(posedge clk);
    @(negedge clk);
    checkAll("R8", 4'b0101, 4'b0101, 2'b00, 2'b01);
    seqRun = 1'b1;
    repeat (2) @(posedge clk);
    @(negedge clk);
    checkAll("R9", 4'b0101, 4'b1010, 2'b00, 2'b01);

    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", nRun, nFail);
    $finish;
  end

endmodule